// File: doc/BRIEF.md
# Multi-mode down-counter timer channel

One binary timer channel of configurable width (16 bits by default). A load strobe captures an initial count and an operating mode. From then on the channel decrements on each cycle where the counter clock enable is high and the gate allows it. It drives one output line whose waveform depends on the mode.

Six behaviours are available:
- a terminal-count interrupt (mode 0)
- a gate-triggered one-shot (mode 1)
- a rate generator (mode 2)
- a square-wave generator (mode 3)
- a software-triggered strobe (mode 4)
- a gate-triggered strobe (mode 5)

A separate register block reads the live count and the output level.

The mode code is the 3-bit binary value on `mode_i`, sampled together with the count on the load strobe. Everything that changes state is registered, so the count and the output take their new values on the clock edge where the causing input is seen.

Top module: `tmr_channel`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `out_o` is low, and the mode is 0.
- R2: An initial count of 0 acts as 65536 (2^W): the first counter tick after such a load gives 0xFFFF.
- R3: In modes 0, 1, 4 and 5 each counter tick lowers `count_o` by one, wrapping modulo 2^W. With no tick, no load and no gate retrigger, the count holds. Modes 1 and 5 count regardless of the gate level.
- R4: In mode 3 each tick lowers the count by two. A tick that finds the count at 1 or 2 reloads the initial count and toggles `out_o`. `out_o` is high after the load.
- R5: In mode 2 each tick lowers the count by one. A tick that finds the count at 1 reloads the initial count and drives `out_o` low for that one clock cycle. `out_o` is high otherwise.
- R6: In modes 1, 2, 3 and 5, a rising edge of `gate_i` reloads the initial count. In mode 1 it also drives `out_o` low. In modes 2, 3 and 5 it drives `out_o` high.
- R7: In modes 0, 2, 3 and 4 counter ticks take effect only while `gate_i` is high. In modes 0 and 4 a rising gate edge never reloads the count.
- R8: `load_i` sets `count_o` to `init_i` on the next edge and restarts the sequence. It takes priority over a tick and over a gate retrigger in the same cycle.
- R9: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R10: Output waveforms in the single-shot modes:
  - Mode 0 drives `out_o` low on load and high on the tick that takes the count from 1 to 0; it then stays high.
  - Mode 1 goes low on the trigger and high on reaching zero.
  - Modes 4 and 5 are high after load or trigger. They go low for one clock cycle on the first tick that takes the count from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter clock enable; one tick per cycle high |
| gate_i | input | 1 | Gate: count enable or retrigger, by mode |
| load_i | input | 1 | Load strobe for `init_i` and `mode_i` |
| init_i | input | W (16) | Initial count; 0 means 2^W |
| mode_i | input | 3 | Operating mode code 0..7 |
| count_o | output | W (16) | Live counter value |
| out_o | output | 1 | Channel output level |

## Verification
Each mode is loaded and then run for a tick count just short of, exactly at, and just past its terminal condition. This separates an off-by-one in the terminal decode from a wrong reload value or output polarity. Mode 3 is run with an even and an odd initial count, and a zero initial count is loaded in a one-step mode and in a periodic mode to show the 2^W meaning. Directed sequences exercise the gate:
- a suspension in mode 0, where a later rise must not reload
- retriggers in modes 1, 2 and 5
- a load coinciding with a tick, which shows load priority

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MODE_INT      = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic tmr_mode_e norm_mode(input logic [2:0] m);
    case (m)
      3'd6:    norm_mode = MODE_RATE;
      3'd7:    norm_mode = MODE_SQUARE;
      default: norm_mode = tmr_mode_e'(m);
    endcase
  endfunction
endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic         retrig_i,
  input  logic         step_i,
  input  tmr_mode_e    mode_i,
  output logic [W-1:0] count_o,
  output logic         term_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] count_q, reload_q, count_d;
  logic         periodic;

  assign periodic = (mode_i == MODE_RATE) || (mode_i == MODE_SQUARE);

  // terminal point of the current period, as seen by the next tick
  always_comb begin
    if (mode_i == MODE_SQUARE) term_o = (count_q == ONE) || (count_q == TWO);
    else                       term_o = (count_q == ONE);
  end

  always_comb begin
    count_d = count_q;
    if (load_i)                      count_d = init_i;
    else if (retrig_i)               count_d = reload_q;
    else if (step_i) begin
      if (periodic && term_o)        count_d = reload_q;
      else if (mode_i == MODE_SQUARE) count_d = count_q - TWO;
      else                           count_d = count_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q <= count_d;
      if (load_i) reload_q <= init_i;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  tmr_mode_e mode_new_i,
  input  tmr_mode_e mode_i,
  input  logic      retrig_i,
  input  logic      step_i,
  input  logic      term_i,
  output logic      out_o
);
  logic out_q, out_d, armed_q, armed_d;

  always_comb begin
    out_d   = out_q;
    armed_d = armed_q;
    if (load_i) begin
      out_d   = (mode_new_i != MODE_INT);
      armed_d = 1'b1;
    end else if (retrig_i) begin
      out_d   = (mode_i != MODE_ONESHOT);
      armed_d = 1'b1;
    end else begin
      case (mode_i)
        MODE_INT, MODE_ONESHOT: if (step_i && term_i) out_d = 1'b1;
        MODE_RATE:              out_d = ~(step_i && term_i);
        MODE_SQUARE:            if (step_i && term_i) out_d = ~out_q;
        default: begin
          // strobe modes: single low cycle, only once per load or trigger
          out_d = 1'b1;
          if (step_i && term_i && armed_q) begin
            out_d   = 1'b0;
            armed_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      armed_q <= armed_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         gate_i,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic [2:0]   mode_i,
  output logic [W-1:0] count_o,
  output logic         out_o
);
  tmr_mode_e mode_q, mode_new;
  logic      rise, run, retrig, step, term, gate_free;

  assign mode_new = norm_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_INT;
    else if (load_i) mode_q <= mode_new;
  end

  tmr_gate_edge u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(gate_i),
    .rise_o(rise)
  );

  // gate-triggered modes count regardless of gate level
  assign gate_free = (mode_q == MODE_ONESHOT) || (mode_q == MODE_HWSTROBE);
  assign run       = cnt_en_i & (gate_i | gate_free);
  assign retrig    = rise & (mode_q != MODE_INT) & (mode_q != MODE_SWSTROBE);
  assign step      = run & ~load_i & ~retrig;

  tmr_count_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .init_i  (init_i),
    .retrig_i(retrig),
    .step_i  (step),
    .mode_i  (mode_q),
    .count_o (count_o),
    .term_o  (term)
  );

  tmr_out_gen u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .mode_new_i(mode_new),
    .mode_i    (mode_q),
    .retrig_i  (retrig),
    .step_i    (step),
    .term_i    (term),
    .out_o     (out_o)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         gate_i,
  input logic         load_i,
  input logic [W-1:0] init_i,
  input logic [2:0]   mode_i,
  input logic [W-1:0] count_o,
  input logic         out_o
);
  logic [2:0] seen_mode;
  logic       gate_prev;
  logic       no_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_mode <= 3'd0;
      gate_prev <= 1'b0;
    end else begin
      gate_prev <= gate_i;
      if (load_i) seen_mode <= (mode_i == 3'd6) ? 3'd2 : (mode_i == 3'd7) ? 3'd3 : mode_i;
    end
  end

  assign no_rise = !(gate_i && !gate_prev);

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(init_i)); // R8

  AST_MODE0_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == 3'd0) |=> !out_o); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_i && no_rise) |=> $stable(count_o)); // R3

  AST_MODE0_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && gate_i && gate_prev && seen_mode == 3'd0)
      |=> count_o == $past(count_o) - W'(1)); // R3

  AST_MODE3_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && gate_i && gate_prev && seen_mode == 3'd3 && count_o > W'(2))
      |=> count_o == $past(count_o) - W'(2)); // R4
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (.*);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] init;
    logic [7:0]  ticks;
    logic [15:0] cnt;
    logic        out;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd5, 8'd3, 16'd2,      1'b0, 8'd3 },  // R3
    '{3'd0, 16'd5, 8'd5, 16'd0,      1'b1, 8'd10},  // R10
    '{3'd0, 16'd5, 8'd7, 16'hFFFE,   1'b1, 8'd3 },  // R3 wrap
    '{3'd2, 16'd4, 8'd3, 16'd1,      1'b1, 8'd5 },  // R5
    '{3'd2, 16'd4, 8'd4, 16'd4,      1'b0, 8'd5 },  // R5
    '{3'd2, 16'd4, 8'd5, 16'd3,      1'b1, 8'd5 },  // R5
    '{3'd3, 16'd6, 8'd2, 16'd2,      1'b1, 8'd4 },  // R4
    '{3'd3, 16'd6, 8'd3, 16'd6,      1'b0, 8'd4 },  // R4
    '{3'd3, 16'd6, 8'd6, 16'd6,      1'b1, 8'd4 },  // R4
    '{3'd3, 16'd5, 8'd3, 16'd5,      1'b0, 8'd4 },  // R4 odd
    '{3'd4, 16'd3, 8'd3, 16'd0,      1'b0, 8'd10},  // R10
    '{3'd4, 16'd3, 8'd4, 16'hFFFF,   1'b1, 8'd10},  // R10
    '{3'd6, 16'd4, 8'd4, 16'd4,      1'b0, 8'd9 },  // R9
    '{3'd7, 16'd6, 8'd3, 16'd6,      1'b0, 8'd9 },  // R9
    '{3'd0, 16'd0, 8'd1, 16'hFFFF,   1'b0, 8'd2 },  // R2
    '{3'd2, 16'd0, 8'd1, 16'hFFFF,   1'b1, 8'd2 },  // R2
    '{3'd1, 16'd3, 8'd2, 16'd1,      1'b1, 8'd3 }   // R3
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic         gate_i = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] init_i = '0;
  logic [2:0]   mode_i = '0;
  logic [W-1:0] count_o;
  logic         out_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_channel #(.W(W)) u0 (.*);

  task automatic check(string tag, logic [W-1:0] exp_cnt, logic exp_out);
    n_tests++;
    if (count_o !== exp_cnt || out_o !== exp_out) begin
      n_fail++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               tag, count_o, out_o, exp_cnt, exp_out);
    end
  endtask

  task automatic do_load(logic [2:0] m, logic [W-1:0] v);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = m; init_i = v; cnt_en_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic run_ticks(int n);
    cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_i = 1'b0;
    @(negedge clk_i);
    gate_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", '0, 1'b0);  // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      do_load(VECS[i].mode, VECS[i].init);
      run_ticks(int'(VECS[i].ticks));
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].cnt, VECS[i].out);
    end

    // R7: gate suspends mode 0; a later rise does not reload
    do_load(3'd0, 16'd5);
    run_ticks(2);
    check("R7 mode0 gated run", 16'd3, 1'b0);
    gate_i = 1'b0;
    run_ticks(3);
    check("R7 mode0 gate low hold", 16'd3, 1'b0);
    gate_i = 1'b1;
    @(negedge clk_i);
    check("R7 mode0 rise no reload", 16'd3, 1'b0);
    run_ticks(1);
    check("R7 mode0 resumes", 16'd2, 1'b0);

    // R6: retrigger in mode 2
    do_load(3'd2, 16'd10);
    run_ticks(3);
    check("R6 mode2 before retrigger", 16'd7, 1'b1);
    gate_pulse();
    check("R6 mode2 retrigger", 16'd10, 1'b1);

    // R6 and R10: one-shot trigger and completion
    do_load(3'd1, 16'd5);
    run_ticks(2);
    check("R10 mode1 high before trigger", 16'd3, 1'b1);
    gate_pulse();
    check("R6 mode1 trigger", 16'd5, 1'b0);
    run_ticks(5);
    check("R10 mode1 reaches zero", 16'd0, 1'b1);

    // R6 and R10: hardware strobe
    do_load(3'd5, 16'd3);
    run_ticks(1);
    gate_pulse();
    check("R6 mode5 retrigger", 16'd3, 1'b1);
    run_ticks(3);
    check("R10 mode5 strobe low", 16'd0, 1'b0);

    // R8: load beats a tick in the same cycle
    do_load(3'd2, 16'd4);
    run_ticks(2);
    @(negedge clk_i);
    load_i = 1'b1; init_i = 16'd20; mode_i = 3'd2; cnt_en_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    check("R8 load priority", 16'd20, 1'b1);
    @(negedge clk_i);
    cnt_en_i = 1'b0;
    check("R8 count after load", 16'd19, 1'b1);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset mid-run", '0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule